// File: doc/BRIEF.md
# Flash Byte-Programming Sequencer

This block controls a small on-chip code flash array through a parallel programming port. A programmer presents an address, a data byte and a 3-bit operation code, and then pulses an active-low strobe. Each byte write is self-timed and runs for a fixed number of clock cycles. A write can only clear bits, so a byte that already holds data must be erased before it can take a new value. A whole-array erase runs while the strobe is held low with the erase operation selected. If the strobe is released early, the erase is abandoned.

Progress can be watched in two ways. A ready output drops for the whole write or erase. The read path also supports polling: while a byte write is in flight, reading the address being written returns bit 7 inverted against the byte being written. The same registered read path returns three fixed identification bytes in signature mode. It returns all ones for verify reads once both protection bits are set. Strobe edges that arrive while a write is running are dropped and recorded in a sticky error flag.

Top module: `flash_prog_seq`

## Requirements
- R1: Asynchronous reset brings `rdy` to 1, `err` to 0 and `rdata` to FFh. It leaves every array location blank (FFh) and both protection bits clear.
- R2: A write starts on a rising edge of `pgm_n` when `mode` is 1 (byte program), 4 (set protection bit 1) or 5 (set protection bit 2). From the next cycle, `rdy` is 0 for exactly WRITE_CYCLES cycles.
- R3: When a byte write completes, the addressed location holds its previous value ANDed with the written byte.
- R4: During a byte write, a verify read (`mode` 0) of the address being written returns the complement of bit 7 of the written byte, with bits 6:0 showing the location's prior contents. Verify reads of other addresses return their stored values.
- R5: A strobe edge that would start a write or erase while a write is in progress changes no state. It sets `err`, which stays 1 until reset.
- R6: A falling edge of `pgm_n` with `mode` 2 starts an erase. If `pgm_n` stays low for ERASE_CYCLES cycles, every location becomes FFh and both protection bits clear. `rdy` stays 0 throughout the erase.
- R7: If `pgm_n` returns high before the erase interval ends, the erase is abandoned, the array is unchanged, and `rdy` returns to 1 on the next cycle.
- R8: While an erase is running, every non-signature read returns FFh.
- R9: With `mode` 3, addresses 30h, 31h and 32h read 1Eh, 51h, and either FFh (SIG_HIGH_VOLT=1) or 05h. Any other address reads 00h. Protection bits have no effect on these reads.
- R10: While both protection bits are set, verify reads return FFh. Either bit alone leaves verify reads unaffected. The protection bits are never presented on `rdata`.
- R11: `rdata` is registered and reflects the `mode` and `addr` sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Array or signature address |
| wdata | input | 8 | Byte to program |
| mode | input | 3 | Operation: 0 verify, 1 program, 2 erase, 3 signature, 4 protect 1, 5 protect 2 |
| pgm_n | input | 1 | Active-low program/erase strobe |
| rdata | output | 8 | Registered read data |
| rdy | output | 1 | 1 when idle, 0 while writing or erasing |
| err | output | 1 | Sticky flag for strobes dropped while busy |

## Verification
The properties assume that `mode`, `addr` and `wdata` are stable across the clock edge where a strobe edge is sampled. They also assume that `pgm_n` idles high outside of reset, so that the first edge after reset is a real strobe edge. The stimulus changes every input only on falling clock edges, which meets both assumptions. It opens every strobe pulse from the high level and keeps the erase operation selected until the strobe is released. This keeps the start conditions used by the busy and error properties unambiguous.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [2:0] {
    MD_VERIFY    = 3'd0,
    MD_PROGRAM   = 3'd1,
    MD_ERASE     = 3'd2,
    MD_SIGNATURE = 3'd3,
    MD_PROTECT1  = 3'd4,
    MD_PROTECT2  = 3'd5
  } fmode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_ERASE = 2'd2
  } fstate_e;

  typedef enum logic [1:0] {
    WK_BYTE = 2'd0,
    WK_PRT1 = 2'd1,
    WK_PRT2 = 2'd2
  } wkind_e;

  localparam logic [7:0] SIG_MAKER  = 8'h1E;
  localparam logic [7:0] SIG_DEVICE = 8'h51;
  localparam logic [7:0] SIG_HV     = 8'hFF;
  localparam logic [7:0] SIG_LV     = 8'h05;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] val_d;
    logic              hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_comb begin
      val_d = val_q;
      if (clr)      val_d = '1;
      else if (hit) val_d = val_q & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           val_q <= '1;
      else if (clr || hit)  val_q <= val_d;
    end

    assign cell_q[g] = val_q;
  end

  assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/flash_down_counter.sv
module flash_down_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import flash_seq_pkg::*;
#(
  parameter int   ADDR_W        = 8,
  parameter int   WRITE_CYCLES  = 1500,
  parameter int   ERASE_CYCLES  = 10000,
  parameter logic SIG_HIGH_VOLT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [2:0]        mode,
  input  logic              pgm_n,
  output logic [7:0]        rdata,
  output logic              rdy,
  output logic              err
);
  localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  fstate_e           st_q, st_d;
  wkind_e            wk_q, wk_d;
  logic [ADDR_W-1:0] wa_q, wa_d;
  logic [7:0]        wd_q, wd_d;
  logic              pgm_q, err_q, err_d, prt1_q, prt1_d, prt2_q, prt2_d;
  logic [7:0]        rdata_q, rdata_d;

  fmode_e            md;
  logic              rise, fall, start_w, start_e;
  logic              cnt_load, cnt_dec, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic              arr_we, arr_clr;
  logic [7:0]        arr_rd;
  logic [7:0]        sig_val;

  flash_cell_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (arr_we),
    .wr_addr (wa_q),
    .wr_data (wd_q),
    .clr     (arr_clr),
    .rd_addr (addr),
    .rd_data (arr_rd)
  );

  flash_down_counter #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  assign md      = fmode_e'(mode);
  assign rise    = pgm_n & ~pgm_q;
  assign fall    = ~pgm_n & pgm_q;
  assign start_w = rise && (md == MD_PROGRAM || md == MD_PROTECT1 || md == MD_PROTECT2);
  assign start_e = fall && (md == MD_ERASE);

  // fixed identification bytes
  always_comb begin
    if (addr == ADDR_W'(8'h30))      sig_val = SIG_MAKER;
    else if (addr == ADDR_W'(8'h31)) sig_val = SIG_DEVICE;
    else if (addr == ADDR_W'(8'h32)) sig_val = SIG_HIGH_VOLT ? SIG_HV : SIG_LV;
    else                             sig_val = 8'h00;
  end

  // sequencing next state
  always_comb begin
    st_d     = st_q;
    wk_d     = wk_q;
    wa_d     = wa_q;
    wd_d     = wd_q;
    err_d    = err_q;
    prt1_d   = prt1_q;
    prt2_d   = prt2_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    arr_we   = 1'b0;
    arr_clr  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_w) begin
          st_d     = ST_WRITE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(WRITE_CYCLES - 1);
          wa_d     = addr;
          wd_d     = wdata;
          wk_d     = (md == MD_PROTECT1) ? WK_PRT1 :
                     (md == MD_PROTECT2) ? WK_PRT2 : WK_BYTE;
        end else if (start_e) begin
          st_d     = ST_ERASE;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(ERASE_CYCLES - 1);
        end
      end
      ST_WRITE: begin
        if (start_w || start_e) err_d = 1'b1;
        if (cnt_zero) begin
          st_d = ST_IDLE;
          unique case (wk_q)
            WK_PRT1: prt1_d = 1'b1;
            WK_PRT2: prt2_d = 1'b1;
            default: arr_we = 1'b1;
          endcase
        end else begin
          cnt_dec = 1'b1;
        end
      end
      ST_ERASE: begin
        if (pgm_n) begin
          st_d = ST_IDLE;
        end else if (cnt_zero) begin
          st_d    = ST_IDLE;
          arr_clr = 1'b1;
          prt1_d  = 1'b0;
          prt2_d  = 1'b0;
        end else begin
          cnt_dec = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // read path next value
  always_comb begin
    if (md == MD_SIGNATURE)
      rdata_d = sig_val;
    else if (st_q == ST_ERASE || (prt1_q && prt2_q))
      rdata_d = 8'hFF;
    else if (st_q == ST_WRITE && wk_q == WK_BYTE && addr == wa_q)
      rdata_d = {~wd_q[7], arr_rd[6:0]};
    else
      rdata_d = arr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wk_q    <= WK_BYTE;
      wa_q    <= '0;
      wd_q    <= 8'hFF;
      pgm_q   <= 1'b1;
      err_q   <= 1'b0;
      prt1_q  <= 1'b0;
      prt2_q  <= 1'b0;
      rdata_q <= 8'hFF;
    end else begin
      st_q    <= st_d;
      pgm_q   <= pgm_n;
      err_q   <= err_d;
      prt1_q  <= prt1_d;
      prt2_q  <= prt2_d;
      rdata_q <= rdata_d;
      if (cnt_load && start_w) begin
        wk_q <= wk_d;
        wa_q <= wa_d;
        wd_q <= wd_d;
      end
    end
  end

  assign rdata = rdata_q;
  assign rdy   = (st_q == ST_IDLE);
  assign err   = err_q;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk #(
  parameter int   ADDR_W        = 8,
  parameter int   WRITE_CYCLES  = 1500,
  parameter int   ERASE_CYCLES  = 10000,
  parameter logic SIG_HIGH_VOLT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic [2:0]        mode,
  input logic              pgm_n,
  input logic [7:0]        rdata,
  input logic              rdy,
  input logic              err
);
  localparam int MAX_CYC = (WRITE_CYCLES > ERASE_CYCLES) ? WRITE_CYCLES : ERASE_CYCLES;

  logic        prev_pgm;
  logic [31:0] busy_run;
  logic        unused_ok;

  assign unused_ok = ^wdata ^ SIG_HIGH_VOLT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pgm <= 1'b1;
      busy_run <= '0;
    end else begin
      prev_pgm <= pgm_n;
      busy_run <= rdy ? 32'd0 : busy_run + 32'd1;
    end
  end

  assert_write_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && pgm_n && !prev_pgm && (mode == 3'd1 || mode == 3'd4 || mode == 3'd5)) |=> !rdy);

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_err_only_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !$past(rdy));

  assert_erase_starts_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && !pgm_n && prev_pgm && mode == 3'd2) |=> !rdy);

  assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 32'(MAX_CYC));

  assert_signature_maker_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && addr == ADDR_W'(8'h30)) |=> (rdata == 8'h1E));
endmodule

bind flash_prog_seq flash_prog_seq_chk #(
  .ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES),
  .ERASE_CYCLES(ERASE_CYCLES), .SIG_HIGH_VOLT(SIG_HIGH_VOLT)
) u_chk (.*);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int WCY = 12;
  localparam int ECY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [2:0] mode = 3'd0;
  logic pgm_n = 1'b1;
  logic [7:0] rdata;
  logic rdy, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_seq #(.ADDR_W(AW), .WRITE_CYCLES(WCY), .ERASE_CYCLES(ECY), .SIG_HIGH_VOLT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mode(mode),
    .pgm_n(pgm_n), .rdata(rdata), .rdy(rdy), .err(err));

  // behavioural reference
  logic [7:0] m_mem [256];
  int m_st, m_left, m_kind;
  logic [7:0] m_wa, m_wd, m_rd;
  logic m_pq, m_err, m_p1, m_p2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
      m_st = 0; m_left = 0; m_kind = 0; m_wa = 0; m_wd = 8'hFF;
      m_rd = 8'hFF; m_pq = 1; m_err = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      bit up, dn, sw, se;
      up = pgm_n && !m_pq;
      dn = !pgm_n && m_pq;
      sw = up && (mode == 1 || mode == 4 || mode == 5);
      se = dn && (mode == 2);
      if (mode == 3)
        m_rd = (addr == 8'h30) ? 8'h1E : (addr == 8'h31) ? 8'h51 : (addr == 8'h32) ? 8'hFF : 8'h00;
      else if (m_st == 2 || (m_p1 && m_p2)) m_rd = 8'hFF;
      else if (m_st == 1 && m_kind == 1 && addr == m_wa) m_rd = {~m_wd[7], m_mem[addr][6:0]};
      else m_rd = m_mem[addr];
      if (m_st == 0) begin
        if (sw) begin
          m_st = 1; m_left = WCY; m_wa = addr; m_wd = wdata;
          m_kind = (mode == 1) ? 1 : (mode == 4) ? 2 : 3;
        end else if (se) begin
          m_st = 2; m_left = ECY;
        end
      end else if (m_st == 1) begin
        if (sw || se) m_err = 1;
        m_left--;
        if (m_left == 0) begin
          m_st = 0;
          if (m_kind == 1) m_mem[m_wa] = m_mem[m_wa] & m_wd;
          else if (m_kind == 2) m_p1 = 1;
          else m_p2 = 1;
        end
      end else begin
        m_left--;
        if (pgm_n) m_st = 0;
        else if (m_left == 0) begin
          m_st = 0; m_p1 = 0; m_p2 = 0;
          for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
        end
      end
      m_pq = pgm_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11 cycle rdata", rdata, m_rd);
      chk("R2 cycle rdy", rdy, (m_st == 0));
      chk("R5 cycle err", err, m_err);
    end
  end

  task automatic rd(input logic [2:0] md, input logic [7:0] a, input logic [7:0] exp, input string req);
    mode = md; addr = a;
    @(negedge clk);
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [2:0] md, input logic [7:0] a, input logic [7:0] d);
    mode = md; addr = a; wdata = d; pgm_n = 1'b0;
    @(negedge clk);
    pgm_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic settle();
    while (!rdy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R1 reset rdy", rdy, 1);
    chk("R1 reset err", err, 0);
    chk("R1 reset rdata", rdata, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, 8'h05, 8'hFF, "R1 blank array");

    // R2 busy length, R3 stored value
    pulse(3'd1, 8'h05, 8'hA5);
    n = 0;
    while (!rdy) begin n++; @(negedge clk); end
    chk("R2 busy cycles", n, WCY);
    rd(3'd0, 8'h05, 8'hA5, "R3 first write");
    pulse(3'd1, 8'h05, 8'h0F);
    settle();
    rd(3'd0, 8'h05, 8'h05, "R3 AND with old value");

    // R4 data polling, R5 dropped strobe
    pulse(3'd1, 8'h09, 8'hBC);
    rd(3'd0, 8'h09, 8'h7F, "R4 polling inverted bit7");
    rd(3'd0, 8'h05, 8'h05, "R4 other address");
    pulse(3'd1, 8'h20, 8'h00);
    chk("R5 err set", err, 1);
    settle();
    rd(3'd0, 8'h09, 8'hBC, "R4 true data after write");
    rd(3'd0, 8'h20, 8'hFF, "R5 dropped write had no effect");
    chk("R5 err sticky", err, 1);

    // R7 abandoned erase, R8 reads during erase
    mode = 3'd2; addr = 8'h05; pgm_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 busy during erase", rdy, 0);
    chk("R8 read during erase", rdata, 8'hFF);
    pgm_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 ready after abandon", rdy, 1);
    rd(3'd0, 8'h05, 8'h05, "R7 array unchanged");

    // R9 signature
    rd(3'd3, 8'h30, 8'h1E, "R9 maker byte");
    rd(3'd3, 8'h31, 8'h51, "R9 device byte");
    rd(3'd3, 8'h32, 8'hFF, "R9 voltage byte");
    rd(3'd3, 8'h33, 8'h00, "R9 other address");

    // R10 protection
    pulse(3'd4, 8'h00, 8'h00);
    settle();
    rd(3'd0, 8'h05, 8'h05, "R10 one bit leaves verify");
    pulse(3'd5, 8'h00, 8'h00);
    settle();
    rd(3'd0, 8'h05, 8'hFF, "R10 both bits block verify");
    rd(3'd3, 8'h31, 8'h51, "R10 signature still readable");

    // R6 full erase
    mode = 3'd2; addr = 8'h09; pgm_n = 1'b0;
    n = 0;
    @(negedge clk);
    while (!rdy) begin n++; @(negedge clk); end
    chk("R6 erase busy cycles", n, ECY);
    pgm_n = 1'b1;
    @(negedge clk);
    rd(3'd0, 8'h09, 8'hFF, "R6 erased location");
    pulse(3'd1, 8'h05, 8'h12);
    settle();
    rd(3'd0, 8'h05, 8'h12, "R6 protection cleared by erase");
    chk("R5 err survives erase", err, 1);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule